// File: doc/BRIEF.md
# Segmented Two-Level Page Walker

This block turns a logical address, given as a segment selector and a 32-bit offset within that segment, into a physical address. It runs in two stages. The first stage bounds-checks the segment. The second stage walks a two-level page table. All table reads share one memory read port, and at most one read is in flight at any time.

The caller presents a request and the current table pointers. The pointers are the segment table base, the highest legal segment number, and the root of the outer page table. The block samples all of them when it accepts the request.

It first fetches the segment descriptor. From the descriptor it checks the offset against the segment limit and adds the offset to the segment base. This gives a linear address. The walker then uses the top bits of the linear address to index the outer table and the next bits to index the inner table. The frame number found in the inner table, joined with the low twelve bits of the linear address, is the physical address.

A selector out of range ends the request as a trap, with no memory traffic. Other failures end the request as one of three faults:
- an offset past the limit;
- an invalid outer entry;
- an invalid inner entry.

Every request ends with exactly one single-cycle response that carries the physical address or a fault code.

Top module: `segpage_xlate`

## Requirements
- R1: While reset is held and after it is released, `resp_valid` and `mem_rd_req` are low and `req_ready` is high.
- R2: A selector strictly greater than `seg_tbl_len` ends with fault code 1 (trap), `resp_paddr` zero and no memory read. A selector equal to `seg_tbl_len` is legal.
- R3: The descriptor is one 64-bit read at `seg_tbl_base + selector*8`. Read data bits 31:0 hold the segment base and bits 63:32 hold the segment limit.
- R4: An offset strictly greater than the limit ends with fault code 2 after exactly one read. An offset equal to the limit is legal.
- R5: The linear address is base plus offset, modulo 2^32. The outer index is linear bits 31:22, the inner index is bits 21:12 and the page offset is bits 11:0.
- R6: The outer entry is read at `pt_root + outer_index*4`. If its bit 0 (valid) is clear, the request ends with fault code 3 after two reads.
- R7: The inner entry is read at `{outer_entry[31:12], 12'h000} + inner_index*4`. If its bit 0 is clear, the request ends with fault code 4 after three reads.
- R8: A full walk returns fault code 0 and `resp_paddr = {inner_entry[31:12], linear[11:0]}` after three reads.
- R9: `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_ack` arrives, whatever the latency. Read data is taken in the cycle in which `mem_rd_ack` is high.
- R10: `resp_valid` is a one-cycle pulse and `resp_paddr` is zero whenever the fault code is nonzero. `req_ready` is low from acceptance until the response cycle has passed.
- R11: `seg_tbl_base`, `seg_tbl_len` and `pt_root` are sampled at acceptance. Changing them during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_seg | input | 13 | Segment selector |
| req_off | input | 32 | Offset inside the segment |
| seg_tbl_base | input | 32 | Physical address of the segment table |
| seg_tbl_len | input | 13 | Highest legal selector |
| pt_root | input | 32 | Physical address of the outer page table |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Byte address of the table read |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 64 | Read data; page entries use bits 31:0 |
| resp_valid | output | 1 | Result pulse |
| resp_paddr | output | 32 | Physical address, zero on a fault |
| resp_fault | output | 3 | 0 ok, 1 trap, 2 limit, 3 outer invalid, 4 inner invalid |

## Verification
The bench goes after each boundary of the bounds checks:
- A selector equal to the length value must walk. An off-by-one compare would trap it.
- An offset equal to the limit must translate. A design that used greater-or-equal would report a limit fault.

A segment base near the top of the address space makes the linear sum wrap. A design that kept a carry or used the wrong index bits would read the wrong outer entry.

Each outer and inner invalid case is checked for its fault code and for its exact read count. A walker that kept reading after a fault, or stopped too early, shows up in the count.

Read latencies of zero and several cycles are mixed, and the table pointers are changed during a walk. A design that used live pointers, or dropped its request before the acknowledge, returns a wrong result.

// File: rtl/segpage_pkg.sv
package segpage_pkg;
  localparam int SEG_W      = 13;
  localparam int VA_W       = 32;
  localparam int PA_W       = 32;
  localparam int IDX_W      = 10;
  localparam int PG_W       = 12;
  localparam int FRM_W      = PA_W - PG_W;
  localparam int ENT_W      = 2 * VA_W;
  localparam int SEG_ENT_SH = 3;
  localparam int PTE_SH     = 2;
  localparam int PTE_W      = 32;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_SEG_TRAP  = 3'd1,
    FLT_SEG_LIMIT = 3'd2,
    FLT_PG_OUTER  = 3'd3,
    FLT_PG_INNER  = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEG_READ, ST_OUTER_READ, ST_INNER_READ, ST_DONE
  } walk_st_e;

  function automatic logic [PA_W-1:0] seg_entry_addr(input logic [PA_W-1:0] tbl,
                                                     input logic [SEG_W-1:0] sel);
    return tbl + (PA_W'(sel) << SEG_ENT_SH);
  endfunction

  function automatic logic [VA_W-1:0] lin_form(input logic [VA_W-1:0] base,
                                               input logic [VA_W-1:0] off);
    return base + off;
  endfunction

  function automatic logic [IDX_W-1:0] outer_idx(input logic [VA_W-1:0] lin);
    return lin[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] inner_idx(input logic [VA_W-1:0] lin);
    return lin[PG_W+IDX_W-1 : PG_W];
  endfunction

  function automatic logic [PA_W-1:0] pte_slot_addr(input logic [PA_W-1:0] tbl,
                                                    input logic [IDX_W-1:0] idx);
    return tbl + (PA_W'(idx) << PTE_SH);
  endfunction

  function automatic logic [PA_W-1:0] phys_form(input logic [FRM_W-1:0] frm,
                                                input logic [PG_W-1:0] pofs);
    return {frm, pofs};
  endfunction
endpackage

// File: rtl/seg_bound_chk.sv
module seg_bound_chk
  import segpage_pkg::*;
(
  input  logic [SEG_W-1:0] sel,
  input  logic [SEG_W-1:0] sel_max,
  input  logic [VA_W-1:0]  off,
  input  logic [ENT_W-1:0] desc,
  output logic             trap_hit,
  output logic             lim_fault,
  output logic [VA_W-1:0]  lin_addr
);
  logic [VA_W-1:0] seg_base;
  logic [VA_W-1:0] seg_limit;

  assign seg_base  = desc[VA_W-1:0];
  assign seg_limit = desc[ENT_W-1:VA_W];
  assign trap_hit  = sel > sel_max;
  assign lim_fault = off > seg_limit;
  assign lin_addr  = lin_form(seg_base, off);
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import segpage_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [VA_W-1:0]  req_off,
  input  logic [PA_W-1:0]  seg_tbl_base,
  input  logic [PA_W-1:0]  pt_root,
  input  logic             trap_hit,
  input  logic             lim_fault,
  input  logic [VA_W-1:0]  lin_addr,
  output logic [VA_W-1:0]  off_q,
  output logic             mem_rd_req,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_ack,
  input  logic [PTE_W-1:0] pte,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [2:0]       resp_fault
);
  walk_st_e          st;
  logic [SEG_W-1:0]  seg_q;
  logic [PA_W-1:0]   stb_q;
  logic [PA_W-1:0]   root_q;
  logic [VA_W-1:0]   lin_q;
  logic [FRM_W-1:0]  inner_frm_q;
  logic [PA_W-1:0]   paddr_q;
  fault_e            fault_q;

  logic              accept;
  logic              pte_ok;
  logic [FRM_W-1:0]  pte_frm;

  assign accept     = req_valid && (st == ST_IDLE);
  assign req_ready  = (st == ST_IDLE);
  assign pte_ok     = pte[0];
  assign pte_frm    = pte[PTE_W-1:PG_W];
  assign mem_rd_req = (st == ST_SEG_READ) || (st == ST_OUTER_READ) || (st == ST_INNER_READ);
  assign resp_valid = (st == ST_DONE);
  assign resp_paddr = paddr_q;
  assign resp_fault = fault_q;

  always_comb begin
    case (st)
      ST_SEG_READ:   mem_rd_addr = seg_entry_addr(stb_q, seg_q);
      ST_OUTER_READ: mem_rd_addr = pte_slot_addr(root_q, outer_idx(lin_q));
      ST_INNER_READ: mem_rd_addr = pte_slot_addr({inner_frm_q, {PG_W{1'b0}}}, inner_idx(lin_q));
      default:       mem_rd_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      seg_q       <= '0;
      stb_q       <= '0;
      root_q      <= '0;
      off_q       <= '0;
      lin_q       <= '0;
      inner_frm_q <= '0;
      paddr_q     <= '0;
      fault_q     <= FLT_NONE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            seg_q   <= req_seg;
            off_q   <= req_off;
            stb_q   <= seg_tbl_base;
            root_q  <= pt_root;
            paddr_q <= '0;
            if (trap_hit) begin
              fault_q <= FLT_SEG_TRAP;
              st      <= ST_DONE;
            end else begin
              fault_q <= FLT_NONE;
              st      <= ST_SEG_READ;
            end
          end
        end
        ST_SEG_READ: begin
          if (mem_rd_ack) begin
            if (lim_fault) begin
              fault_q <= FLT_SEG_LIMIT;
              st      <= ST_DONE;
            end else begin
              lin_q <= lin_addr;
              st    <= ST_OUTER_READ;
            end
          end
        end
        ST_OUTER_READ: begin
          if (mem_rd_ack) begin
            if (!pte_ok) begin
              fault_q <= FLT_PG_OUTER;
              st      <= ST_DONE;
            end else begin
              inner_frm_q <= pte_frm;
              st          <= ST_INNER_READ;
            end
          end
        end
        ST_INNER_READ: begin
          if (mem_rd_ack) begin
            if (!pte_ok) begin
              fault_q <= FLT_PG_INNER;
            end else begin
              fault_q <= FLT_NONE;
              paddr_q <= phys_form(pte_frm, lin_q[PG_W-1:0]);
            end
            st <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready);

  // R10
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_fault != FLT_NONE) |-> resp_paddr == '0);

  // R2
  trap_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && trap_hit |=> !mem_rd_req && resp_valid && (resp_fault == FLT_SEG_TRAP));

  // R7
  inner_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INNER_READ) |-> mem_rd_addr[PTE_SH-1:0] == '0);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_req && !resp_valid);
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import segpage_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [VA_W-1:0]  req_off,
  input  logic [PA_W-1:0]  seg_tbl_base,
  input  logic [SEG_W-1:0] seg_tbl_len,
  input  logic [PA_W-1:0]  pt_root,
  output logic             mem_rd_req,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_ack,
  input  logic [ENT_W-1:0] mem_rd_data,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [2:0]       resp_fault
);
  logic            trap_hit;
  logic            lim_fault;
  logic [VA_W-1:0] lin_addr;
  logic [VA_W-1:0] off_q;

  seg_bound_chk u_chk (
    .sel       (req_seg),
    .sel_max   (seg_tbl_len),
    .off       (off_q),
    .desc      (mem_rd_data),
    .trap_hit  (trap_hit),
    .lim_fault (lim_fault),
    .lin_addr  (lin_addr)
  );

  walk_ctrl u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_seg      (req_seg),
    .req_off      (req_off),
    .seg_tbl_base (seg_tbl_base),
    .pt_root      (pt_root),
    .trap_hit     (trap_hit),
    .lim_fault    (lim_fault),
    .lin_addr     (lin_addr),
    .off_q        (off_q),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ack   (mem_rd_ack),
    .pte          (mem_rd_data[PTE_W-1:0]),
    .resp_valid   (resp_valid),
    .resp_paddr   (resp_paddr),
    .resp_fault   (resp_fault)
  );
endmodule

// File: tb/segpage_xlate_tb_top.sv
`timescale 1ns/1ps
module segpage_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [12:0] req_seg = '0;
  logic [31:0] req_off = '0;
  logic [31:0] seg_tbl_base = 32'h0000_1000;
  logic [12:0] seg_tbl_len = 13'd3;
  logic [31:0] pt_root = 32'h0000_2000;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic [2:0]  resp_fault;

  always #2.5 clk = ~clk;

  segpage_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .seg_tbl_base(seg_tbl_base),
    .seg_tbl_len(seg_tbl_len), .pt_root(pt_root), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] paddr;
    logic [2:0]  fault;
    int          reads;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int unsigned words[int unsigned];
  int lat = 0;
  int lat_cnt = 0;
  int rd_count = 0;
  int last_rd = 0;

  function automatic logic [31:0] rd32(input logic [31:0] a);
    if (words.exists(a >> 2)) return words[a >> 2];
    return 32'h0;
  endfunction

  task automatic put32(input logic [31:0] a, input logic [31:0] v);
    words[a >> 2] = v;
  endtask

  // Memory model: acknowledges after lat wait cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_rd_req && !mem_rd_ack) begin
      if (lat_cnt >= lat) begin
        mem_rd_ack  <= 1'b1;
        mem_rd_data <= {rd32(mem_rd_addr + 32'd4), rd32(mem_rd_addr)};
        lat_cnt     <= 0;
        rd_count    <= rd_count + 1;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_rd_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", what, act, expv);
    end
  endtask

  // Reference model written from the requirement list
  task automatic model(input logic [12:0] sel, input logic [31:0] off,
                       output logic [31:0] pa, output logic [2:0] f, output int n);
    logic [31:0] base, lim, lin, oe, ie, da;
    pa = 32'h0; f = 3'd0; n = 0;
    if (sel > seg_tbl_len) begin f = 3'd1; return; end
    da = seg_tbl_base + {16'h0, 3'b0, sel, 3'b0} ;
    base = rd32(da); lim = rd32(da + 32'd4); n = 1;
    if (off > lim) begin f = 3'd2; return; end
    lin = base + off;
    oe = rd32(pt_root + {20'h0, lin[31:22], 2'b00}); n = 2;
    if (!oe[0]) begin f = 3'd3; return; end
    ie = rd32({oe[31:12], 12'h000} + {20'h0, lin[21:12], 2'b00}); n = 3;
    if (!ie[0]) begin f = 3'd4; return; end
    pa = {ie[31:12], lin[11:0]};
  endtask

  task automatic launch(input logic [12:0] sel, input logic [31:0] off, input int l, input string tag);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    lat = l;
    model(sel, off, e.paddr, e.fault, e.reads);
    e.tag = tag;
    exp_q.push_back(e);
    req_valid = 1'b1; req_seg = sel; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic xlate(input logic [12:0] sel, input logic [31:0] off, input int l, input string tag);
    launch(sel, off, l, tag);
    drain();
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected response", {29'h0, resp_fault}, 32'h0);
      end else begin
        exp_t e;
        int nr;
        e = exp_q.pop_front();
        nr = rd_count - last_rd;
        last_rd = rd_count;
        check(resp_fault == e.fault, {e.tag, " fault"}, {29'h0, resp_fault}, {29'h0, e.fault});
        check(resp_paddr == e.paddr, {e.tag, " paddr"}, resp_paddr, e.paddr);
        check(nr == e.reads, {e.tag, " reads"}, nr, e.reads);
      end
      @(negedge clk);
      check(!resp_valid, "R10 pulse width", {31'h0, resp_valid}, 32'h0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // segment descriptors: base at +0, limit at +4
    put32(32'h1000, 32'h0040_0000); put32(32'h1004, 32'h0000_FFFF);
    put32(32'h1008, 32'hFFFF_F000); put32(32'h100C, 32'h0000_2FFF);
    put32(32'h1010, 32'h0080_3000); put32(32'h1014, 32'h0000_0100);
    put32(32'h1018, 32'h0C00_0000); put32(32'h101C, 32'hFFFF_FFFF);
    // outer table
    put32(32'h2000, 32'h0000_4001);
    put32(32'h2004, 32'h0000_3001);
    put32(32'h2008, 32'h0000_5001);
    // inner tables
    put32(32'h3000, 32'h000A_B001);
    put32(32'h3004, 32'h0007_7001);
    put32(32'h4000, 32'hFFFF_F001);
    put32(32'h500C, 32'h0001_2001);
    // decoy tables for the R11 pointer change
    put32(32'h9004, 32'h0000_6001);
    put32(32'h6004, 32'h0055_5001);

    repeat (3) @(negedge clk);
    // R1 during reset
    check(!resp_valid, "R1 resp_valid in reset", {31'h0, resp_valid}, 0);
    check(!mem_rd_req, "R1 mem_rd_req in reset", {31'h0, mem_rd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 req_ready after reset", {31'h0, req_ready}, 1);
    check(!mem_rd_req && !resp_valid, "R1 quiet after reset", {30'h0, mem_rd_req, resp_valid}, 0);

    xlate(13'd0, 32'h0000_1ABC, 0, "R8 R3 seg0 full walk");
    xlate(13'd0, 32'h0000_0123, 3, "R8 R9 seg0 slow memory");
    check(rd32(32'h3004) == 32'h0007_7001, "R8 table intact", rd32(32'h3004), 32'h0007_7001);
    xlate(13'd1, 32'h0000_1234, 1, "R5 wrapping linear sum");
    xlate(13'd2, 32'h0000_0100, 0, "R4 offset equal to limit");
    xlate(13'd2, 32'h0000_0101, 2, "R4 offset past limit");
    xlate(13'd3, 32'h0000_0000, 0, "R2 R6 selector equal to length, outer invalid");
    xlate(13'd4, 32'h0000_0000, 0, "R2 selector past length");
    xlate(13'h1FFF, 32'hFFFF_FFFF, 0, "R2 max selector");
    xlate(13'd0, 32'h0000_2000, 1, "R7 inner entry invalid");
    xlate(13'd1, 32'h0000_2FFF, 0, "R5 wrap into second inner slot");

    // R11: change pointers during a slow walk
    launch(13'd0, 32'h0000_1004, 6, "R11 pointers sampled at accept");
    @(negedge clk);
    pt_root = 32'h0000_9000; seg_tbl_len = 13'd0; seg_tbl_base = 32'h0000_7000;
    drain();
    pt_root = 32'h0000_2000; seg_tbl_len = 13'd3; seg_tbl_base = 32'h0000_1000;

    // R10 back-to-back requests
    launch(13'd5, 32'h0, 0, "R10 back-to-back trap");
    launch(13'd0, 32'h0000_0FFF, 0, "R10 back-to-back walk");
    drain();
    @(negedge clk);
    check(req_ready, "R10 ready after responses", {31'h0, req_ready}, 1);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule